// File: doc/BRIEF.md
# Banked Event Interrupt Aggregator

The block gathers one-cycle event notifications from many sources into three pending banks of 32 bits each. An event arrives as a 7-bit event number together with a valid strobe. The two upper bits of the number pick the bank and the five lower bits pick the bit, so up to 96 distinct events can be tracked. A pending bit stays set until software clears it.

Each bank holds three mask registers, one per interrupt line. Line A, line B and line C are each high while at least one pending bit in any bank is enabled by that line's mask in the same bank. The lines are level outputs meant for three separate inputs of a CPU interrupt controller. Line A goes to the most urgent of those inputs, line B to the middle one and line C to the lowest. A small register port lets software read the pending and mask registers, load the masks, and clear pending bits by writing ones.

Top module: `evt_irq_aggr`

## Requirements
- R1: An event number selects its pending bank from bits 6:5 (bank 0, 1 or 2) and its bit from bits 4:0.
- R2: A valid event sets exactly the selected pending bit. Every other pending bit keeps its value.
- R3: An event whose bits 6:5 equal 3 changes no pending bit.
- R4: A write to a pending register clears each bit that is 1 in the written data. Bits written as 0 keep their value.
- R5: If an event and a pending-register write target the same bit in the same cycle, the bit ends up set.
- R6: Register address bits 3:2 select the bank and bits 1:0 select the register: 0 is pending, 1 is mask A, 2 is mask B, 3 is mask C. Masks are written and read back whole. Any address with bank field 3 reads as zero, and writes to it are ignored.
- R7: The interrupt outputs are registered. irq_line[0] is line A, irq_line[1] is line B and irq_line[2] is line C. Each line is the OR over all banks of that bank's pending bits ANDed with the bank's mask for the line. A change to a pending bit or to a mask shows on the line one clock later.
- R8: After a clear, a line falls only if no masked pending bit remains for that line in any bank.
- R9: A synchronous active-high reset clears all pending bits, all masks, the read data and all interrupt lines.
- R10: bus_rdata shows, one clock after an address is presented, the register value at the moment of that clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| evt_valid | input | 1 | Event strobe, one cycle per event |
| evt_num | input | 7 | Event number: bits 6:5 bank, bits 4:0 bit |
| bus_wr | input | 1 | Register write enable |
| bus_addr | input | 4 | Register address: bits 3:2 bank, bits 1:0 register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| irq_line | output | 3 | Level interrupt lines: bit 0 A, bit 1 B, bit 2 C |

## Verification
A wrong pending bit shows up in two places, both one clock after the fault: in the read-back of its bank, and on every line whose mask covers it. A pending bit that sticks or never sets shows as a line that stays high or never rises. Cross-bank errors show up the same way. A line that falls while another bank still holds an enabled event, or a line that stays high after its last enabled bit is cleared, is seen on the clock after the clearing write. The stimulus therefore spreads enabled events over several banks and clears them one at a time.

// File: rtl/evt_aggr_pkg.sv
package evt_aggr_pkg;
  localparam int NUM_BANKS_DEF = 3;
  localparam int BANK_W_DEF    = 32;
  localparam int NUM_LINES_DEF = 3;
  localparam int EVT_W_DEF     = 7;

  // register selector within a bank (address bits 1:0)
  typedef enum logic [1:0] {
    RSEL_PEND   = 2'd0,
    RSEL_MASK_A = 2'd1,
    RSEL_MASK_B = 2'd2,
    RSEL_MASK_C = 2'd3
  } rsel_e;
endpackage

// File: rtl/evt_decode.sv
module evt_decode #(
  parameter int NUM_BANKS = 3,
  parameter int BANK_W    = 32,
  parameter int EVT_W     = 7
) (
  input  logic                              evt_valid,
  input  logic [EVT_W-1:0]                  evt_num,
  output logic [NUM_BANKS-1:0][BANK_W-1:0]  set_vec
);
  localparam int POS_W  = $clog2(BANK_W);
  localparam int BSEL_W = EVT_W - POS_W;

  logic [POS_W-1:0]  pos;
  logic [BSEL_W-1:0] bsel;
  assign pos  = evt_num[POS_W-1:0];
  assign bsel = evt_num[EVT_W-1:POS_W];

  // a bank number without a matching bank decodes to nothing
  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    assign set_vec[b] = (evt_valid && (bsel == BSEL_W'(b))) ?
                        (BANK_W'(1) << pos) : '0;
  end
endmodule

// File: rtl/evt_bank.sv
module evt_bank #(
  parameter int BANK_W    = 32,
  parameter int NUM_LINES = 3
) (
  input  logic                              clk,
  input  logic                              rst,
  input  logic [BANK_W-1:0]                 set_vec,
  input  logic                              pend_wr,
  input  logic [NUM_LINES-1:0]              mask_wr,
  input  logic [BANK_W-1:0]                 wdata,
  output logic [BANK_W-1:0]                 pend_q,
  output logic [NUM_LINES-1:0][BANK_W-1:0]  mask_q,
  output logic [NUM_LINES-1:0]              hit
);
  // pending: write-one-to-clear, a same-cycle event wins
  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q <= '0;
    end else if (pend_wr) begin
      pend_q <= (pend_q & ~wdata) | set_vec;
    end else begin
      pend_q <= pend_q | set_vec;
    end
  end

  for (genvar j = 0; j < NUM_LINES; j++) begin : g_line
    always_ff @(posedge clk) begin
      if (rst)             mask_q[j] <= '0;
      else if (mask_wr[j]) mask_q[j] <= wdata;
    end
    assign hit[j] = |(pend_q & mask_q[j]);
  end

  p_set_sticks_r2: assert property (@(posedge clk) disable iff (rst)
    (set_vec != '0) |=> ((pend_q & $past(set_vec)) == $past(set_vec)))
    else $error("event bit not set");

  p_event_wins_r5: assert property (@(posedge clk) disable iff (rst)
    (pend_wr && ((set_vec & wdata) != '0)) |=> ((pend_q & $past(set_vec)) != '0))
    else $error("clear beat a same-cycle event");

  p_clear_r4: assert property (@(posedge clk) disable iff (rst)
    pend_wr |=> ((pend_q & $past(wdata) & ~$past(set_vec)) == '0))
    else $error("written one did not clear");

  p_hold_r2: assert property (@(posedge clk) disable iff (rst)
    (!pend_wr && (set_vec == '0)) |=> $stable(pend_q))
    else $error("pending changed without cause");

  p_mask_hold_r6: assert property (@(posedge clk) disable iff (rst)
    (mask_wr == '0) |=> $stable(mask_q))
    else $error("mask changed without write");
endmodule

// File: rtl/evt_irq_reduce.sv
module evt_irq_reduce #(
  parameter int NUM_BANKS = 3,
  parameter int NUM_LINES = 3
) (
  input  logic                                 clk,
  input  logic                                 rst,
  input  logic [NUM_BANKS-1:0][NUM_LINES-1:0]  hit,
  output logic [NUM_LINES-1:0]                 irq_q
);
  logic [NUM_LINES-1:0] any_hit;

  always_comb begin
    any_hit = '0;
    for (int b = 0; b < NUM_BANKS; b++) any_hit = any_hit | hit[b];
  end

  always_ff @(posedge clk) begin
    if (rst) irq_q <= '0;
    else     irq_q <= any_hit;
  end
endmodule

// File: rtl/evt_irq_aggr.sv
module evt_irq_aggr
  import evt_aggr_pkg::*;
#(
  parameter int NUM_BANKS = NUM_BANKS_DEF,
  parameter int BANK_W    = BANK_W_DEF,
  parameter int NUM_LINES = NUM_LINES_DEF,
  parameter int EVT_W     = EVT_W_DEF
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 evt_valid,
  input  logic [EVT_W-1:0]     evt_num,
  input  logic                 bus_wr,
  input  logic [3:0]           bus_addr,
  input  logic [BANK_W-1:0]    bus_wdata,
  output logic [BANK_W-1:0]    bus_rdata,
  output logic [NUM_LINES-1:0] irq_line
);
  localparam int RSEL_W = 2;
  localparam int BA_W   = 2;

  logic [NUM_BANKS-1:0][BANK_W-1:0]                 set_vec;
  logic [NUM_BANKS-1:0][BANK_W-1:0]                 pend_q;
  logic [NUM_BANKS-1:0][NUM_LINES-1:0][BANK_W-1:0]  mask_q;
  logic [NUM_BANKS-1:0][NUM_LINES-1:0]              hit;
  logic [BA_W-1:0]   addr_bank;
  logic [RSEL_W-1:0] addr_rsel;
  logic [BANK_W-1:0] rd_next;

  assign addr_bank = bus_addr[3:2];
  assign addr_rsel = bus_addr[1:0];

  evt_decode #(.NUM_BANKS(NUM_BANKS), .BANK_W(BANK_W), .EVT_W(EVT_W)) u_decode (
    .evt_valid (evt_valid),
    .evt_num   (evt_num),
    .set_vec   (set_vec)
  );

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    logic                 pend_wr;
    logic [NUM_LINES-1:0] mask_wr;
    assign pend_wr = bus_wr && (addr_bank == BA_W'(b)) &&
                     (addr_rsel == RSEL_PEND);
    for (genvar j = 0; j < NUM_LINES; j++) begin : g_mw
      assign mask_wr[j] = bus_wr && (addr_bank == BA_W'(b)) &&
                          (addr_rsel == RSEL_W'(j + 1));
    end
    evt_bank #(.BANK_W(BANK_W), .NUM_LINES(NUM_LINES)) u_bank (
      .clk     (clk),
      .rst     (rst),
      .set_vec (set_vec[b]),
      .pend_wr (pend_wr),
      .mask_wr (mask_wr),
      .wdata   (bus_wdata),
      .pend_q  (pend_q[b]),
      .mask_q  (mask_q[b]),
      .hit     (hit[b])
    );
  end

  evt_irq_reduce #(.NUM_BANKS(NUM_BANKS), .NUM_LINES(NUM_LINES)) u_reduce (
    .clk   (clk),
    .rst   (rst),
    .hit   (hit),
    .irq_q (irq_line)
  );

  // read mux: unmapped bank numbers return zero
  always_comb begin
    rd_next = '0;
    for (int b = 0; b < NUM_BANKS; b++) begin
      if (addr_bank == BA_W'(b)) begin
        if (addr_rsel == RSEL_PEND) rd_next = pend_q[b];
        for (int j = 0; j < NUM_LINES; j++)
          if (addr_rsel == RSEL_W'(j + 1)) rd_next = mask_q[b][j];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) bus_rdata <= '0;
    else     bus_rdata <= rd_next;
  end

  p_invalid_bank_r3: assert property (@(posedge clk) disable iff (rst)
    (evt_valid && (evt_num[EVT_W-1:EVT_W-2] == 2'b11) && !bus_wr) |=> $stable(pend_q))
    else $error("invalid event altered pending state");

  p_reset_r9: assert property (@(posedge clk)
    rst |=> ((irq_line == '0) && (bus_rdata == '0)))
    else $error("reset left outputs active");

  p_quiet_low_r8: assert property (@(posedge clk) disable iff (rst)
    (pend_q == '0) |=> (irq_line == '0))
    else $error("line high with nothing pending");

  p_unmasked_low_r7: assert property (@(posedge clk) disable iff (rst)
    (mask_q == '0) |=> (irq_line == '0))
    else $error("line high with all masks clear");

  p_bank3_zero_r6: assert property (@(posedge clk) disable iff (rst)
    (addr_bank == 2'b11) |=> (bus_rdata == '0))
    else $error("unmapped bank read nonzero");
endmodule

// File: tb/test_evt_irq_aggr.sv
`timescale 1ns/1ps
module test_evt_irq_aggr;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        evt_valid = 1'b0;
  logic [6:0]  evt_num = '0;
  logic        bus_wr = 1'b0;
  logic [3:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [2:0]  irq_line;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #4 clk = ~clk;

  evt_irq_aggr i_evt_irq_aggr (
    .clk(clk), .rst(rst), .evt_valid(evt_valid), .evt_num(evt_num),
    .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .irq_line(irq_line)
  );

  typedef struct packed {
    logic        is_evt;
    logic [6:0]  num;
    logic [3:0]  addr;
    logic [31:0] data;
    logic [2:0]  exp_irq;
  } vec_t;

  // addr: bits 3:2 bank, bits 1:0 0=pend 1=A 2=B 3=C ; irq bit0=A bit1=B bit2=C
  localparam vec_t TBL [12] = '{
    '{1'b0, 7'h00, 4'd1,  32'h0000_0001, 3'b000}, // R6 mask A bank0
    '{1'b1, 7'h00, 4'd0,  32'h0,         3'b001}, // R1 R7 bank0 bit0
    '{1'b0, 7'h00, 4'd10, 32'h8000_0000, 3'b001}, // mask B bank2
    '{1'b1, 7'h5F, 4'd0,  32'h0,         3'b011}, // R1 bank2 bit31
    '{1'b0, 7'h00, 4'd7,  32'h0000_0010, 3'b011}, // mask C bank1
    '{1'b1, 7'h24, 4'd0,  32'h0,         3'b111}, // bank1 bit4
    '{1'b1, 7'h64, 4'd0,  32'h0,         3'b111}, // R3 invalid bank
    '{1'b0, 7'h00, 4'd0,  32'h0000_0001, 3'b110}, // R4 clear bank0 bit0
    '{1'b0, 7'h00, 4'd5,  32'h0000_0010, 3'b111}, // R7 mask write next cycle
    '{1'b0, 7'h00, 4'd4,  32'h0000_0000, 3'b111}, // R4 zero write no effect
    '{1'b0, 7'h00, 4'd4,  32'h0000_0010, 3'b010}, // R8 bank1 cleared
    '{1'b0, 7'h00, 4'd8,  32'hFFFF_FFFF, 3'b000}  // R8 last bit gone
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic idle();
    evt_valid = 1'b0; bus_wr = 1'b0;
    @(negedge clk);
  endtask

  task automatic fire(input logic [6:0] n);
    evt_num = n; evt_valid = 1'b1;
    @(negedge clk);
    idle();
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    idle();
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    bus_addr = a; bus_wr = 1'b0;
    @(negedge clk);
    d = bus_rdata;
  endtask

  initial begin
    logic [31:0] v;
    logic [31:0] b0, b1, b2;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R9 reset state
    chk("R9 irq after reset", 32'(irq_line), 32'h0);
    rd(4'd0, v);  chk("R9 pending bank0", v, 32'h0);
    rd(4'd11, v); chk("R9 mask C bank2", v, 32'h0);

    // R7 table walk
    foreach (TBL[i]) begin
      if (TBL[i].is_evt) fire(TBL[i].num);
      else               wr(TBL[i].addr, TBL[i].data);
      chk($sformatf("R7 vector %0d irq", i), 32'(irq_line), 32'(TBL[i].exp_irq));
    end

    // R6 / R10 mask read back and unmapped bank
    rd(4'd10, v); chk("R6 R10 mask B bank2", v, 32'h8000_0000);
    rd(4'd5, v);  chk("R6 mask A bank1", v, 32'h0000_0010);
    wr(4'd13, 32'hFFFF_FFFF);
    rd(4'd13, v); chk("R6 bank3 reads zero", v, 32'h0);

    // R1 R2 set selected bits only
    fire(7'h25); fire(7'h3F);
    rd(4'd4, v); chk("R1 R2 pending bank1", v, 32'h8000_0020);
    rd(4'd0, v); chk("R2 pending bank0 untouched", v, 32'h0);

    // R3 invalid bank: no pending register changes
    rd(4'd0, b0);
    fire(7'h7F); fire(7'h60);
    rd(4'd0, v); chk("R3 bank0 unchanged", v, b0);
    rd(4'd4, v); chk("R3 bank1 unchanged", v, 32'h8000_0020);
    rd(4'd8, v); chk("R3 bank2 unchanged", v, 32'h0);

    // R5 same-cycle event and clear
    evt_num = 7'h25; evt_valid = 1'b1;
    bus_addr = 4'd4; bus_wdata = 32'hFFFF_FFFF; bus_wr = 1'b1;
    @(negedge clk);
    idle();
    rd(4'd4, v); chk("R5 event beats clear", v, 32'h0000_0020);

    // R4 partial clear
    fire(7'h21); fire(7'h22);
    wr(4'd4, 32'h0000_0022);
    rd(4'd4, v); chk("R4 partial clear", v, 32'h0000_0004);
    wr(4'd4, 32'hFFFF_FFFF);

    // R8 line held by another bank
    wr(4'd1, 32'h0000_0004);
    wr(4'd9, 32'h0000_0008);
    fire(7'h02); fire(7'h43);
    chk("R8 line A up", 32'(irq_line[0]), 32'h1);
    wr(4'd0, 32'h0000_0004);
    chk("R8 A held by bank2", 32'(irq_line[0]), 32'h1);
    wr(4'd8, 32'h0000_0008);
    chk("R8 A falls", 32'(irq_line[0]), 32'h0);

    // R9 reset mid-run
    fire(7'h02); fire(7'h43);
    rst = 1'b1; @(negedge clk); rst = 1'b0; @(negedge clk);
    chk("R9 irq after mid reset", 32'(irq_line), 32'h0);
    rd(4'd1, v); chk("R9 mask cleared", v, 32'h0);
    rd(4'd8, b2); chk("R9 pending cleared", b2, 32'h0);
    b1 = b2;

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule